// File: doc/BRIEF.md
# Digital Potentiometer Command Executor

This block sits behind a two-wire serial link layer in a digitally controlled potentiometer. The link layer recognises START and STOP, matches the device address and assembles bytes. It then hands this block one pulse for an identification byte that matched, one pulse with the byte for every later byte, one pulse for STOP, and a pulse with a direction for each increment/decrement clock. The block decodes the instruction byte and runs the command. It tells the link layer whether to acknowledge each byte, whether a data byte is expected, and what byte to return on a read.

The block holds the volatile wiper position and sixteen 8-bit retained data registers. The registers form four banks of four. A store into a retained register begins at the STOP that ends the command and runs for a programmable number of clocks. The register takes its new value when that period ends. While the period runs, the device refuses to acknowledge its identification byte. An active-low write-protect input blocks all such stores. On reset, the wiper is loaded from register 0 of bank 0.

Top module: `pot_cmd_exec`

## Requirements
- R1: After reset every data register holds RESET_VAL, the wiper equals register 0 of bank 0 (RESET_VAL), busy is low, and txValid, needData and incActive are low.
- R2: The instruction byte carries the opcode in bits 7:4, the register select in bits 3:2 and the bank select in bits 1:0 (register address = bank*4 + register). Opcodes are 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 register to wiper, 1110 wiper to register, and 0010 step. Any other opcode is not acknowledged and changes no state. Later bytes of that command are also not acknowledged.
- R3: Wiper read, wiper write, both transfers and step are accepted only when the bank select is 00. Otherwise the instruction byte is not acknowledged and nothing changes.
- R4: After an acknowledged read instruction, txValid is high and txData holds the wiper or the selected register from the next cycle until STOP. txValid is never high while busy.
- R5: Write wiper takes a third byte. That byte is acknowledged and becomes the wiper position on the following cycle.
- R6: Write register works in all four banks. Its data byte is staged. The store begins at STOP, busy stays high for exactly WRITE_CYCLES cycles, and the register holds the byte once busy falls.
- R7: Register to wiper loads the wiper from the selected bank-0 register when the instruction byte is accepted. Wiper to register stores the current wiper into the selected bank-0 register through the busy period that starts at STOP.
- R8: With wpN low at STOP, a write-register or wiper-to-register command starts no busy period and leaves the register unchanged.
- R9: While busy, an identification byte is not acknowledged and the wiper does not move.
- R10: A write command whose STOP arrives before its data byte leaves every register unchanged and starts no busy period.
- R11: In step mode, each incStep moves the wiper up by one when incUp is 1 and down by one when incUp is 0. The wiper saturates at 0xFF and 0x00.
- R12: ackValid pulses in the cycle after every idStb or byteStb, and only then. ackOut then gives the acknowledge decision. An identification byte is acknowledged whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpN | input | 1 | Write protect, low blocks retained stores |
| idStb | input | 1 | Matched identification byte received |
| byteStb | input | 1 | Byte after the identification byte received |
| byteIn | input | 8 | Received byte, valid with byteStb |
| stopStb | input | 1 | STOP condition seen |
| incStep | input | 1 | One increment/decrement clock in step mode |
| incUp | input | 1 | Step direction, 1 = up |
| ackValid | output | 1 | Acknowledge decision valid this cycle |
| ackOut | output | 1 | 1 = acknowledge the last byte |
| needData | output | 1 | Next byte is a write data byte |
| txValid | output | 1 | txData is to be sent to the master |
| txData | output | 8 | Byte returned by a read |
| incActive | output | 1 | Step mode active |
| busy | output | 1 | Retained store in progress |
| wiperPos | output | 8 | Wiper position to the tap decoder |

## Verification
The hardest state to reach from the ports is the busy period. A register's new value cannot be read while it runs, and its length can only be seen as the busy output together with refused acknowledges. The stimulus commits a store and then counts busy cycles sample by sample. It sends an identification byte straight after STOP to see the refusal, and reads the register back only once busy has fallen. Write-protect and early-STOP cases are checked the same way: busy must stay low at once, and a later read must return the old value.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int BANK_W   = 2;
  localparam int SEL_W    = 2;
  localparam int ADDR_W   = BANK_W + SEL_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_DATA  = 4'b1011;
  localparam logic [3:0] OP_WR_DATA  = 4'b1100;
  localparam logic [3:0] OP_TO_WIPER = 4'b1101;
  localparam logic [3:0] OP_TO_DATA  = 4'b1110;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INSTR, ST_DATA, ST_SEND, ST_INC, ST_PEND, ST_HOLD
  } cmdState_t;

  typedef struct packed {
    logic              wrWiper;
    logic              xfrToWiper;
    logic              stepUp;
    logic              stepDn;
    logic              stageByte;
    logic              commitNv;
    logic              nvFromWiper;
    logic              txFromWiper;
    logic [ADDR_W-1:0] addr;
  } cmdStrobes_t;
endpackage

// File: rtl/pot_cmd_ctrl.sv
module pot_cmd_ctrl
  import pot_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              busy,
  input  logic              idStb,
  input  logic              byteStb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              stopStb,
  input  logic              incStep,
  input  logic              incUp,
  output cmdStrobes_t       stb,
  output logic              ackValid,
  output logic              ackOut,
  output logic              txValid,
  output logic              needData,
  output logic              incActive
);
  cmdState_t         state, stNext;
  logic [ADDR_W-1:0] addrQ, addrNext;
  logic              toWiperQ, toWiperNext;
  logic              fromWiperQ, fromWiperNext;
  logic              txWiperQ, txWiperNext;
  logic              ackEvt, ackNow;

  logic [3:0]        opcode;
  logic [BANK_W-1:0] bankSel;
  logic [SEL_W-1:0]  regSel;
  logic              bankZero;

  assign opcode   = byteIn[7:4];
  assign regSel   = byteIn[3:2];
  assign bankSel  = byteIn[1:0];
  assign bankZero = (bankSel == '0);

  always_comb begin
    stNext           = state;
    addrNext         = addrQ;
    toWiperNext      = toWiperQ;
    fromWiperNext    = fromWiperQ;
    txWiperNext      = txWiperQ;
    ackEvt           = 1'b0;
    ackNow           = 1'b0;
    stb              = '0;
    stb.addr         = addrQ;
    stb.nvFromWiper  = fromWiperQ;
    stb.txFromWiper  = txWiperQ;

    if (idStb) begin
      ackEvt = 1'b1;
      if (busy) begin
        stNext = ST_IDLE;
      end else begin
        ackNow = 1'b1;
        stNext = ST_INSTR;
      end
    end else if (stopStb) begin
      if (state == ST_PEND && wpN) stb.commitNv = 1'b1;
      stNext = ST_IDLE;
    end else if (byteStb) begin
      ackEvt = 1'b1;
      case (state)
        ST_INSTR: begin
          addrNext = {bankSel, regSel};
          stNext   = ST_HOLD;
          case (opcode)
            OP_RD_WIPER: if (bankZero) begin
              ackNow = 1'b1; txWiperNext = 1'b1; stNext = ST_SEND;
            end
            OP_WR_WIPER: if (bankZero) begin
              ackNow = 1'b1; toWiperNext = 1'b1; stNext = ST_DATA;
            end
            OP_RD_DATA: begin
              ackNow = 1'b1; txWiperNext = 1'b0; stNext = ST_SEND;
            end
            OP_WR_DATA: begin
              ackNow = 1'b1; toWiperNext = 1'b0; fromWiperNext = 1'b0;
              stNext = ST_DATA;
            end
            OP_TO_WIPER: if (bankZero) begin
              ackNow = 1'b1; stb.xfrToWiper = 1'b1;
              stb.addr = {bankSel, regSel};
            end
            OP_TO_DATA: if (bankZero) begin
              ackNow = 1'b1; fromWiperNext = 1'b1; stNext = ST_PEND;
            end
            OP_STEP: if (bankZero) begin
              ackNow = 1'b1; stNext = ST_INC;
            end
            default: ;
          endcase
        end
        ST_DATA: begin
          ackNow = 1'b1;
          if (toWiperQ) begin
            stb.wrWiper = 1'b1;
            stNext      = ST_HOLD;
          end else begin
            stb.stageByte = 1'b1;
            stNext        = ST_PEND;
          end
        end
        default: ;
      endcase
    end else if (incStep && state == ST_INC) begin
      stb.stepUp = incUp;
      stb.stepDn = !incUp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      addrQ      <= '0;
      toWiperQ   <= 1'b0;
      fromWiperQ <= 1'b0;
      txWiperQ   <= 1'b0;
      ackValid   <= 1'b0;
      ackOut     <= 1'b0;
    end else begin
      state      <= stNext;
      addrQ      <= addrNext;
      toWiperQ   <= toWiperNext;
      fromWiperQ <= fromWiperNext;
      txWiperQ   <= txWiperNext;
      ackValid   <= ackEvt;
      ackOut     <= ackNow;
    end
  end

  assign txValid   = (state == ST_SEND);
  assign needData  = (state == ST_DATA);
  assign incActive = (state == ST_INC);
endmodule

// File: rtl/pot_cmd_dpath.sv
module pot_cmd_dpath
  import pot_cmd_pkg::*;
#(
  parameter int          WRITE_CYCLES = 50000,
  parameter logic [7:0]  RESET_VAL    = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       stb,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [BYTE_W-1:0] wiperPos,
  output logic [BYTE_W-1:0] txData,
  output logic              busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);
  localparam logic [BYTE_W-1:0] POS_MAX = '1;
  localparam logic [BYTE_W-1:0] POS_MIN = '0;

  logic [BYTE_W-1:0] dataReg [NUM_REGS];
  logic [BYTE_W-1:0] wiper, staged, pendData;
  logic [ADDR_W-1:0] pendAddr;
  logic [CNT_W-1:0]  cnt;
  logic              lastCycle;

  assign busy      = (cnt != '0);
  assign lastCycle = (cnt == CNT_W'(1));

  // Retained cells: each updates only at the end of a busy period
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN)
        dataReg[gi] <= RESET_VAL;
      else if (lastCycle && pendAddr == ADDR_W'(gi))
        dataReg[gi] <= pendData;
    end
  end

  // Wiper counter: recalled from bank 0 register 0 on reset
  always_ff @(posedge clk) begin
    if (!rstN)
      wiper <= RESET_VAL;
    else if (stb.wrWiper)
      wiper <= byteIn;
    else if (stb.xfrToWiper)
      wiper <= dataReg[stb.addr];
    else if (stb.stepUp && wiper != POS_MAX)
      wiper <= wiper + 1'b1;
    else if (stb.stepDn && wiper != POS_MIN)
      wiper <= wiper - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staged   <= '0;
      pendData <= '0;
      pendAddr <= '0;
      cnt      <= '0;
    end else begin
      if (stb.stageByte) staged <= byteIn;
      if (stb.commitNv) begin
        pendAddr <= stb.addr;
        pendData <= stb.nvFromWiper ? wiper : staged;
        cnt      <= CNT_LOAD;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign wiperPos = wiper;
  assign txData   = stb.txFromWiper ? wiper : dataReg[stb.addr];
endmodule

// File: rtl/pot_cmd_exec.sv
module pot_cmd_exec
  import pot_cmd_pkg::*;
#(
  parameter int         WRITE_CYCLES = 50000,
  parameter logic [7:0] RESET_VAL    = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpN,
  input  logic       idStb,
  input  logic       byteStb,
  input  logic [7:0] byteIn,
  input  logic       stopStb,
  input  logic       incStep,
  input  logic       incUp,
  output logic       ackValid,
  output logic       ackOut,
  output logic       needData,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       incActive,
  output logic       busy,
  output logic [7:0] wiperPos
);
  cmdStrobes_t stb;

  pot_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wpN(wpN), .busy(busy),
    .idStb(idStb), .byteStb(byteStb), .byteIn(byteIn), .stopStb(stopStb),
    .incStep(incStep), .incUp(incUp), .stb(stb),
    .ackValid(ackValid), .ackOut(ackOut), .txValid(txValid),
    .needData(needData), .incActive(incActive)
  );

  pot_cmd_dpath #(.WRITE_CYCLES(WRITE_CYCLES), .RESET_VAL(RESET_VAL)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIn(byteIn),
    .wiperPos(wiperPos), .txData(txData), .busy(busy)
  );
endmodule

// File: rtl/pot_cmd_exec_chk.sv
module pot_cmd_exec_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic       idStb,
  input logic       byteStb,
  input logic       stopStb,
  input logic       incStep,
  input logic       incUp,
  input logic       ackValid,
  input logic       ackOut,
  input logic       needData,
  input logic       txValid,
  input logic       incActive,
  input logic       busy,
  input logic [7:0] wiperPos
);
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (idStb && busy) |=> (ackValid && !ackOut)); // R9
  AST_WIPER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wiperPos)); // R9
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !wpN && !busy) |=> !busy); // R8
  AST_TX_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !busy); // R4
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txValid, needData, incActive})); // R2
  AST_STEP_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (incActive && incStep && incUp && !idStb && !stopStb && wiperPos == 8'hFF)
      |=> wiperPos == 8'hFF); // R11
  AST_STEP_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (incActive && incStep && !incUp && !idStb && !stopStb && wiperPos == 8'h00)
      |=> wiperPos == 8'h00); // R11
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (idStb || byteStb) |=> ackValid); // R12
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(idStb || byteStb) |=> !ackValid); // R12
endmodule

bind pot_cmd_exec pot_cmd_exec_chk u_chk (
  .clk(clk), .rstN(rstN), .wpN(wpN), .idStb(idStb), .byteStb(byteStb),
  .stopStb(stopStb), .incStep(incStep), .incUp(incUp), .ackValid(ackValid),
  .ackOut(ackOut), .needData(needData), .txValid(txValid),
  .incActive(incActive), .busy(busy), .wiperPos(wiperPos)
);

// File: tb/pot_cmd_exec_tb.sv
`timescale 1ns/1ps
module pot_cmd_exec_tb;
  localparam int WCYC = 20;
  localparam logic [7:0] RV = 8'h80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, wpN = 1'b1, idStb = 1'b0, byteStb = 1'b0, stopStb = 1'b0;
  logic incStep = 1'b0, incUp = 1'b0;
  logic [7:0] byteIn = '0;
  logic ackValid, ackOut, needData, txValid, incActive, busy;
  logic [7:0] txData, wiperPos;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  pot_cmd_exec #(.WRITE_CYCLES(WCYC), .RESET_VAL(RV)) u_dut (
    .clk(clk), .rstN(rstN), .wpN(wpN), .idStb(idStb), .byteStb(byteStb),
    .byteIn(byteIn), .stopStb(stopStb), .incStep(incStep), .incUp(incUp),
    .ackValid(ackValid), .ackOut(ackOut), .needData(needData),
    .txValid(txValid), .txData(txData), .incActive(incActive),
    .busy(busy), .wiperPos(wiperPos)
  );

  // {bank, register, data}
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 2'd1, 8'h3C}, {2'd1, 2'd0, 8'hA5}, {2'd2, 2'd3, 8'h5A},
    {2'd3, 2'd2, 8'hC3}, {2'd3, 2'd3, 8'h01}, {2'd1, 2'd2, 8'hFE}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R12 watchdog expired actual=%0d expected<=50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseId(output logic a);
    @(negedge clk) idStb = 1'b1;
    @(negedge clk) idStb = 1'b0;
    a = ackOut;
  endtask

  task automatic pulseByte(input logic [7:0] b, output logic a);
    @(negedge clk) begin byteStb = 1'b1; byteIn = b; end
    @(negedge clk) byteStb = 1'b0;
    a = ackOut;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopStb = 1'b1;
    @(negedge clk) stopStb = 1'b0;
  endtask

  task automatic pulseStep(input logic up);
    @(negedge clk) begin incStep = 1'b1; incUp = up; end
    @(negedge clk) incStep = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic writeCmd(input logic [7:0] instr, input logic [7:0] data, output logic allAck);
    logic a0, a1, a2;
    pulseId(a0);
    pulseByte(instr, a1);
    pulseByte(data, a2);
    pulseStop();
    allAck = a0 & a1 & a2;
  endtask

  task automatic readCmd(input logic [7:0] instr, output logic ok, output logic [7:0] v);
    logic a0, a1;
    pulseId(a0);
    pulseByte(instr, a1);
    ok = a0 & a1 & txValid;
    v  = txData;
    pulseStop();
  endtask

  initial begin
    logic a, ok;
    logic [7:0] v;
    int n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state and power-on recall
    check(wiperPos == RV, "R1 wiper after reset", wiperPos, RV);
    check(!busy && !txValid && !needData && !incActive, "R1 idle flags",
          {busy, txValid, needData, incActive}, 0);
    readCmd(8'hB0, ok, v);
    check(ok && v == RV, "R1 bank0 reg0 reset value", v, RV);

    // R6: vector table, write every entry then read every entry back
    foreach (VEC[i]) begin
      writeCmd({4'hC, VEC[i][9:8], VEC[i][11:10]}, VEC[i][7:0], a);
      check(a == 1'b1, "R6 write register acked", a, 1);
      waitIdle(n);
    end
    foreach (VEC[i]) begin
      readCmd({4'hB, VEC[i][9:8], VEC[i][11:10]}, ok, v);
      check(ok && v == VEC[i][7:0], "R6 register readback", v, VEC[i][7:0]);
    end

    // R2: undefined opcodes refused, no state change
    pulseId(a);
    pulseByte(8'h00, a);
    check(a == 1'b0, "R2 opcode 0000 nacked", a, 0);
    pulseByte(8'hF3, a);
    check(a == 1'b0 && !txValid && !needData && !incActive && wiperPos == RV,
          "R2 later byte ignored", {a, wiperPos}, {1'b0, RV});
    pulseStop();

    // R5 / R4: write wiper then read it
    writeCmd(8'hA0, 8'h33, a);
    check(a && wiperPos == 8'h33, "R5 write wiper", wiperPos, 8'h33);
    readCmd(8'h90, ok, v);
    check(ok && v == 8'h33, "R4 read wiper", v, 8'h33);

    // R3: bank restriction
    pulseId(a);
    pulseByte(8'hA1, a);
    check(a == 1'b0 && !needData, "R3 write wiper bank1 nacked", a, 0);
    pulseByte(8'h11, a);
    check(wiperPos == 8'h33, "R3 wiper unchanged", wiperPos, 8'h33);
    pulseStop();
    pulseId(a);
    pulseByte(8'h91, a);
    check(a == 1'b0 && !txValid, "R3 read wiper bank1 nacked", a, 0);
    pulseStop();
    pulseId(a);
    pulseByte(8'h22, a);
    check(a == 1'b0 && !incActive, "R3 step bank2 nacked", a, 0);
    pulseStop();

    // R7: register to wiper
    pulseId(a);
    pulseByte(8'hD4, a);
    check(a && wiperPos == 8'h3C, "R7 register to wiper", wiperPos, 8'h3C);
    pulseStop();
    pulseId(a);
    pulseByte(8'hD6, a);
    check(a == 1'b0 && wiperPos == 8'h3C, "R7 transfer bank2 nacked", wiperPos, 8'h3C);
    pulseStop();

    // R7: wiper to register
    writeCmd(8'hA0, 8'h77, a);
    pulseId(a);
    pulseByte(8'hE8, a);
    pulseStop();
    check(busy == 1'b1, "R7 store started", busy, 1);
    waitIdle(n);
    readCmd(8'hB8, ok, v);
    check(ok && v == 8'h77, "R7 wiper stored to reg2", v, 8'h77);

    // R8: write protect blocks both kinds of store
    wpN = 1'b0;
    writeCmd(8'hCC, 8'h99, a);
    check(busy == 1'b0, "R8 no busy on protected write", busy, 0);
    readCmd(8'hBC, ok, v);
    check(ok && v == RV, "R8 register unchanged", v, RV);
    pulseId(a);
    pulseByte(8'hEC, a);
    pulseStop();
    check(busy == 1'b0, "R8 no busy on protected transfer", busy, 0);
    readCmd(8'hBC, ok, v);
    check(ok && v == RV, "R8 register unchanged after transfer", v, RV);
    wpN = 1'b1;

    // R6: busy length
    writeCmd(8'hC9, 8'h5E, a);
    waitIdle(n);
    check(n == WCYC, "R6 busy cycles", n, WCYC);
    readCmd(8'hB9, ok, v);
    check(ok && v == 8'h5E, "R6 bank1 reg2 after busy", v, 8'h5E);

    // R9: identification refused while busy
    writeCmd(8'hC5, 8'h42, a);
    pulseId(a);
    check(a == 1'b0 && busy, "R9 id nacked while busy", a, 0);
    check(wiperPos == 8'h77, "R9 wiper held while busy", wiperPos, 8'h77);
    waitIdle(n);
    readCmd(8'hB5, ok, v);
    check(ok && v == 8'h42, "R9 store completed", v, 8'h42);

    // R12: acknowledge pulse timing
    @(negedge clk) idStb = 1'b1;
    @(negedge clk) idStb = 1'b0;
    check(ackValid && ackOut, "R12 ack pulse after id", {ackValid, ackOut}, 3);
    @(negedge clk);
    check(!ackValid, "R12 ack pulse one cycle", ackValid, 0);
    pulseStop();

    // R10: STOP before data discards the write
    pulseId(a);
    pulseByte(8'hC5, a);
    check(needData == 1'b1, "R10 data expected", needData, 1);
    pulseStop();
    check(busy == 1'b0, "R10 no busy", busy, 0);
    readCmd(8'hB5, ok, v);
    check(ok && v == 8'h42, "R10 register unchanged", v, 8'h42);

    // R11: stepping with saturation
    writeCmd(8'hA0, 8'hFD, a);
    pulseId(a);
    pulseByte(8'h20, a);
    check(a && incActive, "R11 step mode entered", incActive, 1);
    pulseStep(1'b1);
    check(wiperPos == 8'hFE, "R11 step up", wiperPos, 8'hFE);
    pulseStep(1'b1);
    pulseStep(1'b1);
    check(wiperPos == 8'hFF, "R11 saturate high", wiperPos, 8'hFF);
    pulseStop();
    writeCmd(8'hA0, 8'h02, a);
    pulseId(a);
    pulseByte(8'h20, a);
    pulseStep(1'b0);
    check(wiperPos == 8'h01, "R11 step down", wiperPos, 8'h01);
    pulseStep(1'b0);
    pulseStep(1'b0);
    check(wiperPos == 8'h00, "R11 saturate low", wiperPos, 8'h00);
    pulseStop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule